// File: doc/BRIEF.md
# Aligned Chunked CSR Register Multiplexer

This block sits on a narrow control/status bus (address, read strobe, write strobe and a data path a few bits wide). It serves a set of registers that are each wider than that bus. Every register is cut into bus-wide chunks placed at consecutive addresses. An alignment factor rounds the number of chunks a register takes up to a whole number of words of the wider processor that reaches the bus through a width down-converter. With alignment 1 a register takes exactly as many chunks as its width needs. With alignment 4 on an 8-bit bus, every register takes a multiple of four chunks, and the chunks past the register's real width are padding.

Writes into the lower chunks only fill a per-register holding buffer. The write that lands on the final chunk of the aligned span, padding or not, moves the whole assembled value into the register in one step and raises a one-cycle commit pulse for that register. Reads are made coherent in a similar way. Reading chunk 0 takes a copy of the register's read-data input into a read shadow, and the higher chunks are then served from that copy. A multi-chunk read therefore sees one value even if the register changes part way through. Read data is registered.

Top module: `csr_chunk_mux`

## Requirements
- R1: After reset every register value output is zero, no commit pulse is high, and the read data output is zero.
- R2: With the default parameters (8-bit data, 8-bit address, widths 8, 16 and 24) a register's index is address bits [7:2] and its chunk index is address bits [1:0]. Chunk c carries register bits [8c+7:8c].
- R3: A write to a chunk that is not the last of a register's aligned span leaves that register's value output unchanged and raises no commit pulse. A register value output never changes without its commit pulse.
- R4: A write to the last chunk of the span updates the register's value output with all buffered chunks plus the current data, in the cycle after the strobe. In that same cycle exactly that register's commit bit is high, and it is low again in the next cycle when no further committing write follows.
- R5: A register of w bits spans ceil(w/(8*A))*A chunks, where A is the alignment. With A=1 the 8/16/24-bit registers need 1/2/3 writes. With A=4 each needs 4 writes, and the 4th write commits.
- R6: Write data for padding chunks (bits at or above the register width) is dropped: those value bits stay zero. Reading a padding chunk returns zero.
- R7: A read of chunk 0 captures the whole register from its read-data input. Reads of higher chunks return that captured value, even after the register has been updated in between.
- R8: Read data appears on the output in the cycle after the read strobe and holds while no read strobe is given.
- R9: An access to an unmapped address reads zero and has no effect. An address is unmapped if its register index is at or above the register count, or its chunk index is at or beyond the register's span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | ADDR_W | Bus address |
| csr_rd_i | input | 1 | Read strobe |
| csr_wr_i | input | 1 | Write strobe |
| csr_wdata_i | input | DATA_W | Write data |
| csr_rdata_o | output | DATA_W | Registered read data |
| reg_value_o | output | NUM_REGS*MAX_W | Committed register values, register i at bits [i*MAX_W +: MAX_W] |
| reg_commit_o | output | NUM_REGS | One-cycle commit pulse per register |
| reg_rdata_i | input | NUM_REGS*MAX_W | Live register read values, same packing |

## Verification
Two instances are driven: one with alignment 1 and one with alignment 4. On each, the registers of 8, 16 and 24 bits are written chunk by chunk, and value and commit are sampled after every write. This separates a commit on the last real chunk from a commit on the last aligned chunk. Writes of nonzero data into padding chunks show whether padding bits leak into the value. Writes and reads to a chunk past a short span, and to a register index that does not exist, show whether unmapped accesses are ignored. A chunk-0 read followed by a full rewrite and then reads of the higher chunks tells a read shadow apart from a live pass-through.

// File: rtl/csr_chunk_pkg.sv
package csr_chunk_pkg;

    // Number of bus chunks a register of w bits occupies for a given alignment.
    function automatic int unsigned span_of(input int unsigned w,
                                            input int unsigned dw,
                                            input int unsigned al);
        return ((w + dw * al - 1) / (dw * al)) * al;
    endfunction

    // Address bits used for the chunk index (at least one).
    function automatic int unsigned chunk_bits(input int unsigned max_span);
        return (max_span <= 1) ? 1 : $clog2(max_span);
    endfunction

endpackage

// File: rtl/csr_chunk_decode.sv
module csr_chunk_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ALIGN    = 1,
    parameter int unsigned CHUNK_AW = 2,
    parameter int unsigned NUM_REGS = 3,
    parameter int unsigned REG_WIDTHS [NUM_REGS] = '{8, 16, 24}
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] hit_o,
    output logic [NUM_REGS-1:0] last_o,
    output logic [CHUNK_AW-1:0] chunk_o
);
    localparam int unsigned SEL_W = ADDR_W - CHUNK_AW;

    logic [SEL_W-1:0] sel;

    assign sel     = addr_i[ADDR_W-1:CHUNK_AW];
    assign chunk_o = addr_i[CHUNK_AW-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int unsigned SPAN =
            csr_chunk_pkg::span_of(REG_WIDTHS[g], DATA_W, ALIGN);
        assign hit_o[g]  = (sel == SEL_W'(g)) &&
                           ({1'b0, chunk_o} < (CHUNK_AW + 1)'(SPAN));
        assign last_o[g] = (chunk_o == CHUNK_AW'(SPAN - 1));
    end

endmodule

// File: rtl/csr_chunk_slot.sv
module csr_chunk_slot #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CHUNK_AW = 2,
    parameter int unsigned MAX_W    = 24,
    parameter int unsigned W        = 16,
    parameter int unsigned SPAN     = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                hit_i,
    input  logic                last_i,
    input  logic [CHUNK_AW-1:0] chunk_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [W-1:0]        live_i,
    output logic [MAX_W-1:0]    value_o,
    output logic                commit_o,
    output logic [DATA_W-1:0]   rchunk_o
);
    localparam int unsigned BUF_W = SPAN * DATA_W;

    typedef struct packed {
        logic [BUF_W-1:0] wbuf;
        logic [BUF_W-1:0] snap;
        logic [W-1:0]     val;
        logic             commit;
    } slot_t;

    slot_t            s_d, s_q;
    logic [BUF_W-1:0] merged;
    logic [BUF_W-1:0] live_ext;
    logic [BUF_W-1:0] rsrc;

    always_comb begin
        s_d          = s_q;
        s_d.commit   = 1'b0;
        live_ext     = '0;
        live_ext[W-1:0] = live_i;
        merged       = s_q.wbuf;
        merged[chunk_i*DATA_W +: DATA_W] = wdata_i;

        if (hit_i && wr_i) begin
            s_d.wbuf = merged;
            if (last_i) begin
                s_d.val    = merged[W-1:0];
                s_d.commit = 1'b1;
            end
        end

        if (hit_i && rd_i && (chunk_i == '0)) begin
            s_d.snap = live_ext;
        end

        rsrc     = (chunk_i == '0) ? live_ext : s_q.snap;
        rchunk_o = hit_i ? rsrc[chunk_i*DATA_W +: DATA_W] : '0;

        value_o        = '0;
        value_o[W-1:0] = s_q.val;
        commit_o       = s_q.commit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/csr_chunk_mux.sv
module csr_chunk_mux #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned ALIGN    = 1,
    parameter int unsigned NUM_REGS = 3,
    parameter int unsigned MAX_W    = 24,
    parameter int unsigned REG_WIDTHS [NUM_REGS] = '{8, 16, 24}
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [ADDR_W-1:0]         csr_addr_i,
    input  logic                      csr_rd_i,
    input  logic                      csr_wr_i,
    input  logic [DATA_W-1:0]         csr_wdata_i,
    output logic [DATA_W-1:0]         csr_rdata_o,
    output logic [NUM_REGS*MAX_W-1:0] reg_value_o,
    output logic [NUM_REGS-1:0]       reg_commit_o,
    input  logic [NUM_REGS*MAX_W-1:0] reg_rdata_i
);
    localparam int unsigned MAX_SPAN = csr_chunk_pkg::span_of(MAX_W, DATA_W, ALIGN);
    localparam int unsigned CHUNK_AW = csr_chunk_pkg::chunk_bits(MAX_SPAN);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t                top_d, top_q;
    logic [NUM_REGS-1:0] hit, last;
    logic [CHUNK_AW-1:0] chunk;
    logic [DATA_W-1:0]   rchunk [NUM_REGS];
    logic [DATA_W-1:0]   rd_mux;

    csr_chunk_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ALIGN      (ALIGN),
        .CHUNK_AW   (CHUNK_AW),
        .NUM_REGS   (NUM_REGS),
        .REG_WIDTHS (REG_WIDTHS)
    ) u_decode (
        .addr_i  (csr_addr_i),
        .hit_o   (hit),
        .last_o  (last),
        .chunk_o (chunk)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam int unsigned W    = REG_WIDTHS[g];
        localparam int unsigned SPAN = csr_chunk_pkg::span_of(W, DATA_W, ALIGN);

        csr_chunk_slot #(
            .DATA_W   (DATA_W),
            .CHUNK_AW (CHUNK_AW),
            .MAX_W    (MAX_W),
            .W        (W),
            .SPAN     (SPAN)
        ) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .hit_i    (hit[g]),
            .last_i   (last[g]),
            .chunk_i  (chunk),
            .wr_i     (csr_wr_i),
            .rd_i     (csr_rd_i),
            .wdata_i  (csr_wdata_i),
            .live_i   (reg_rdata_i[g*MAX_W +: W]),
            .value_o  (reg_value_o[g*MAX_W +: MAX_W]),
            .commit_o (reg_commit_o[g]),
            .rchunk_o (rchunk[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_mux = rd_mux | rchunk[i];
        end
        top_d       = top_q;
        if (csr_rd_i) begin
            top_d.rdata = rd_mux;
        end
        csr_rdata_o = top_q.rdata;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

endmodule

// File: rtl/csr_chunk_mux_chk.sv
module csr_chunk_mux_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned ALIGN    = 1,
    parameter int unsigned NUM_REGS = 3,
    parameter int unsigned MAX_W    = 24,
    parameter int unsigned REG_WIDTHS [NUM_REGS] = '{8, 16, 24}
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [ADDR_W-1:0]         csr_addr_i,
    input logic                      csr_rd_i,
    input logic                      csr_wr_i,
    input logic [DATA_W-1:0]         csr_wdata_i,
    input logic [DATA_W-1:0]         csr_rdata_o,
    input logic [NUM_REGS*MAX_W-1:0] reg_value_o,
    input logic [NUM_REGS-1:0]       reg_commit_o,
    input logic [NUM_REGS*MAX_W-1:0] reg_rdata_i
);
    localparam int unsigned MAX_SPAN = csr_chunk_pkg::span_of(MAX_W, DATA_W, ALIGN);
    localparam int unsigned CHUNK_AW = csr_chunk_pkg::chunk_bits(MAX_SPAN);
    localparam int unsigned SEL_W    = ADDR_W - CHUNK_AW;

    AST_COMMIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(reg_commit_o)); // R4

    AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|reg_commit_o) |-> $past(csr_wr_i)); // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_rd_i |=> $stable(csr_rdata_o)); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_rd_i && (csr_addr_i[ADDR_W-1:CHUNK_AW] >= SEL_W'(NUM_REGS)))
        |=> (csr_rdata_o == '0)); // R9

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        localparam int unsigned W = REG_WIDTHS[g];

        AST_VALUE_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !reg_commit_o[g] |-> $stable(reg_value_o[g*MAX_W +: MAX_W])); // R3

        if (W < MAX_W) begin : g_pad
            AST_PAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                reg_value_o[g*MAX_W + W +: MAX_W - W] == '0); // R6
        end
    end

endmodule

bind csr_chunk_mux csr_chunk_mux_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .ALIGN      (ALIGN),
    .NUM_REGS   (NUM_REGS),
    .MAX_W      (MAX_W),
    .REG_WIDTHS (REG_WIDTHS)
) u_chk (.*);

// File: tb/csr_chunk_mux_tb.sv
`timescale 1ns/1ps
module csr_chunk_mux_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr   [2];
    logic        rd     [2];
    logic        wr     [2];
    logic [7:0]  wdata  [2];
    logic [7:0]  rdata  [2];
    logic [71:0] value  [2];
    logic [2:0]  commit [2];
    logic        mon_v  [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int         k;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    csr_chunk_mux #(.ALIGN(1)) u_dut (
        .clk_i (clk), .rst_ni (rst_n),
        .csr_addr_i (addr[0]), .csr_rd_i (rd[0]), .csr_wr_i (wr[0]),
        .csr_wdata_i (wdata[0]), .csr_rdata_o (rdata[0]),
        .reg_value_o (value[0]), .reg_commit_o (commit[0]),
        .reg_rdata_i (value[0])
    );

    csr_chunk_mux #(.ALIGN(4)) u_dut_a4 (
        .clk_i (clk), .rst_ni (rst_n),
        .csr_addr_i (addr[1]), .csr_rd_i (rd[1]), .csr_wr_i (wr[1]),
        .csr_wdata_i (wdata[1]), .csr_rdata_o (rdata[1]),
        .reg_value_o (value[1]), .reg_commit_o (commit[1]),
        .reg_rdata_i (value[1])
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input int k, input int i);
        return {8'h00, value[k][i*24 +: 24]};
    endfunction

    task automatic csr_write(input int k, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr[k] = a; wdata[k] = d; wr[k] = 1'b1;
        @(negedge clk);
        wr[k] = 1'b0;
    endtask

    task automatic csr_read(input int k, input logic [7:0] a, input logic [7:0] exp,
                            input string req);
        item_t it;
        @(negedge clk);
        addr[k] = a; rd[k] = 1'b1;
        it.k = k; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        rd[k] = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: the cycle after a read strobe, pop the expected chunk and compare.
    always @(posedge clk) begin
        mon_v[0] <= rd[0];
        mon_v[1] <= rd[1];
    end

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && mon_v[k]) begin
                if (sb_q.size() == 0) begin
                    chk("R8 unexpected read", 32'h1, 32'h0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(it.req, {24'h0, rdata[it.k]}, {24'h0, it.exp});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            addr[k] = '0; rd[k] = 1'b0; wr[k] = 1'b0; wdata[k] = '0; mon_v[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 3; i++) chk("R1 value", val(k, i), 32'h0);
            chk("R1 commit", {29'h0, commit[k]}, 32'h0);
            chk("R1 rdata", {24'h0, rdata[k]}, 32'h0);
        end

        // ---------------- alignment 1 ----------------
        csr_write(0, 8'h00, 8'hA5);
        chk("R4 8-bit commit value", val(0, 0), 32'hA5);
        chk("R4 commit pulse", {29'h0, commit[0]}, 32'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", {29'h0, commit[0]}, 32'h0);

        csr_write(0, 8'h04, 8'h34);
        chk("R3 low chunk no update", val(0, 1), 32'h0);
        chk("R3 low chunk no commit", {29'h0, commit[0]}, 32'h0);
        csr_write(0, 8'h05, 8'h12);
        chk("R4 16-bit assembled", val(0, 1), 32'h1234);
        chk("R4 commit reg1", {29'h0, commit[0]}, 32'h2);

        csr_write(0, 8'h08, 8'h11);
        csr_write(0, 8'h09, 8'h22);
        chk("R3 24-bit after 2 writes", val(0, 2), 32'h0);
        csr_write(0, 8'h0A, 8'h33);
        chk("R5 24-bit commits on 3rd write", val(0, 2), 32'h332211);
        chk("R5 commit reg2", {29'h0, commit[0]}, 32'h4);

        csr_write(0, 8'h0B, 8'hFF);
        chk("R9 beyond span no commit", {29'h0, commit[0]}, 32'h0);
        chk("R9 beyond span no change", val(0, 2), 32'h332211);
        csr_write(0, 8'h0C, 8'h77);
        chk("R9 missing reg no commit", {29'h0, commit[0]}, 32'h0);
        chk("R9 reg0 untouched", val(0, 0), 32'hA5);

        csr_read(0, 8'h0B, 8'h00, "R9 read beyond span");
        csr_read(0, 8'h0C, 8'h00, "R9 read missing reg");
        csr_read(0, 8'h04, 8'h34, "R2 chunk0 of reg1");
        csr_read(0, 8'h05, 8'h12, "R2 chunk1 of reg1");
        csr_read(0, 8'h00, 8'hA5, "R8 one-cycle read latency");
        @(negedge clk);
        chk("R8 rdata holds", {24'h0, rdata[0]}, 32'hA5);

        // R7 coherent read across an update
        csr_read(0, 8'h08, 8'h11, "R7 snapshot chunk0");
        csr_write(0, 8'h08, 8'hAA);
        csr_write(0, 8'h09, 8'hBB);
        csr_write(0, 8'h0A, 8'hCC);
        chk("R4 rewrite reg2", val(0, 2), 32'hCCBBAA);
        csr_read(0, 8'h09, 8'h22, "R7 chunk1 from snapshot");
        csr_read(0, 8'h0A, 8'h33, "R7 chunk2 from snapshot");
        csr_read(0, 8'h08, 8'hAA, "R7 new snapshot");
        csr_read(0, 8'h0A, 8'hCC, "R7 new chunk2");

        // ---------------- alignment 4 ----------------
        csr_write(1, 8'h00, 8'h5A);
        chk("R5 a4 8-bit not yet", val(1, 0), 32'h0);
        csr_write(1, 8'h01, 8'h77);
        csr_write(1, 8'h02, 8'h77);
        chk("R5 a4 8-bit after 3 writes", val(1, 0), 32'h0);
        chk("R5 a4 no commit yet", {29'h0, commit[1]}, 32'h0);
        csr_write(1, 8'h03, 8'h99);
        chk("R6 a4 padding dropped", val(1, 0), 32'h5A);
        chk("R5 a4 commit on 4th", {29'h0, commit[1]}, 32'h1);

        csr_write(1, 8'h08, 8'h01);
        csr_write(1, 8'h09, 8'h02);
        csr_write(1, 8'h0A, 8'h03);
        chk("R5 a4 24-bit after 3 writes", val(1, 2), 32'h0);
        csr_write(1, 8'h0B, 8'hEE);
        chk("R5 a4 24-bit commit on padding", val(1, 2), 32'h030201);
        chk("R5 a4 commit reg2", {29'h0, commit[1]}, 32'h4);

        csr_write(1, 8'h04, 8'hCD);
        csr_write(1, 8'h05, 8'hAB);
        csr_write(1, 8'h06, 8'hFF);
        chk("R3 a4 16-bit before last", val(1, 1), 32'h0);
        csr_write(1, 8'h07, 8'hFF);
        chk("R6 a4 16-bit padding dropped", val(1, 1), 32'hABCD);

        csr_read(1, 8'h08, 8'h01, "R2 a4 chunk0");
        csr_read(1, 8'h0B, 8'h00, "R6 a4 padding read");
        csr_read(1, 8'h0A, 8'h03, "R2 a4 chunk2");
        csr_read(1, 8'h00, 8'h5A, "R2 a4 reg0");
        csr_read(1, 8'h01, 8'h00, "R6 a4 reg0 padding read");
        csr_read(1, 8'h0C, 8'h00, "R9 a4 missing reg");

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", sb_q.size(), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule